// File: doc/BRIEF.md
# Performance Monitor Counter Unit

This block counts processor activity for profiling. It holds one free-running cycle counter and two event counters. Each event counter takes its input from one line of a 256-line bus of single-cycle event pulses, chosen by an 8-bit code. A single control/status word holds the whole configuration: the global run bit, the counter-clear actions, a divide-by-64 mode for the cycle counter, one interrupt enable per counter, one sticky overflow flag per counter and the two event codes.

Software loads a counter with the two's-complement negative of a sample period and enables counting. When the counter steps from all-ones to zero, its overflow flag sets. If that counter's interrupt enable is on, the level interrupt rises and stays high until the flag is cleared. A handler reads the control word and writes the same value back. That write clears every flag that was seen set, and the handler may drop the run bit in the same write.

Top module: `perf_mon_unit`

## Requirements
- R1: While control bit 0 (run) is 0, none of the three counters changes except through a direct write or a clear action.
- R2: Event counter k (k = 0, 1) adds one on each clock where run is 1 and `event_pulse[code_k]` is 1. code_0 is control bits [19:12] and code_1 is control bits [27:20]. Code 0xFF means no event, and that counter never advances.
- R3: With run set and control bit 3 clear, the cycle counter adds one per clock. With bit 3 set, it adds one on every 64th running clock, counted by a prescaler of running clocks.
- R4: Writing control with bit 1 set zeroes both event counters. Writing control with bit 2 set zeroes the cycle counter and its prescaler. Either clear wins over an increment on the same clock. Both bits read back as 0.
- R5: Overflow flags sit at control bits 8, 9 and 10, for event counter 0, event counter 1 and the cycle counter. A flag sets when its counter increments from 0xFFFFFFFF to 0.
- R6: Flags are write-one-to-clear, and writing 0 to a flag bit leaves it unchanged. When a wrap and a clear of the same flag fall on one clock, the flag stays set.
- R7: `irq` is high exactly when some flag is set together with its enable. The enables are control bits 4, 5 and 6, in the same counter order as the flags.
- R8: The register address is 0 for control, 1 for the cycle counter, 2 for event counter 0 and 3 for event counter 1. Reads are combinational. Writing back the control value just read clears the flags that were set, and may clear run in the same write.
- R9: A direct counter write wins over an increment on the same clock. The written value is stored and no overflow is flagged for that clock.
- R10: A counter preloaded with 2^32 - N and then counting one step per clock sets its flag on exactly the Nth increment.
- R11: After reset every register reads 0 and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| event_pulse | input | 256 | Single-cycle event pulses, one per code |
| irq | output | 1 | Level interrupt |

## Verification
Two pairs of functions can fall on the same clock. The first pair is a counter wrap and a software flag clear. The bench preloads event counter 0 with all-ones and writes control with flag bit 8 set while driving the selected event pulse in that same cycle. It then expects the flag and `irq` to remain set. The second pair is a direct counter write and a running increment. The bench writes all-ones into the running cycle counter and expects that value, not its successor, one clock later with no flag; the wrap comes on the following clock. A behavioural model in the bench tracks every register and is compared with `reg_rdata` and `irq` on every clock.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int CODE_W   = 8;
  localparam int NUM_EVT  = 1 << CODE_W;
  localparam int NUM_CNT  = 3;
  localparam int IDX_EVT0 = 0;
  localparam int IDX_EVT1 = 1;
  localparam int IDX_CYC  = 2;

  localparam int B_RUN     = 0;
  localparam int B_CLR_EVT = 1;
  localparam int B_CLR_CYC = 2;
  localparam int B_DIV     = 3;
  localparam int B_IE_LSB  = 4;
  localparam int B_OVF_LSB = 8;
  localparam int B_CODE_LSB = 12;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_CYC  = 2'd1,
    SEL_EVT0 = 2'd2,
    SEL_EVT1 = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic [1:0][CODE_W-1:0] code;
    logic [NUM_CNT-1:0]     ie;
    logic                   div;
    logic                   run;
  } pmu_cfg_t;
endpackage

// File: rtl/pmu_ctrl_reg.sv
module pmu_ctrl_reg
  import pmu_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [31:0]        wdata,
  input  logic [NUM_CNT-1:0] wrap,
  output pmu_cfg_t           cfg,
  output logic [NUM_CNT-1:0] ovf,
  output logic               clr_evt,
  output logic               clr_cyc,
  output logic [31:0]        rd_word
);
  pmu_cfg_t           cfg_q, cfg_d;
  logic [NUM_CNT-1:0] ovf_q, ovf_d, ovf_clr;
  logic               ovf_ce;
  logic               unused_wbits;

  assign unused_wbits = ^{wdata[31:28], wdata[11], wdata[7]};

  always_comb begin
    cfg_d      = cfg_q;
    cfg_d.run  = wdata[B_RUN];
    cfg_d.div  = wdata[B_DIV];
    cfg_d.ie   = wdata[B_IE_LSB +: NUM_CNT];
    cfg_d.code = wdata[B_CODE_LSB +: 2*CODE_W];
  end

  always_comb begin
    ovf_clr = wr_en ? wdata[B_OVF_LSB +: NUM_CNT] : '0;
    ovf_d   = (ovf_q & ~ovf_clr) | wrap;
    ovf_ce  = wr_en | (|wrap);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (wr_en) begin
      cfg_q <= cfg_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= '0;
    end else if (ovf_ce) begin
      ovf_q <= ovf_d;
    end
  end

  assign clr_evt = wr_en & wdata[B_CLR_EVT];
  assign clr_cyc = wr_en & wdata[B_CLR_CYC];
  assign cfg     = cfg_q;
  assign ovf     = ovf_q;

  always_comb begin
    rd_word = '0;
    rd_word[B_RUN]                       = cfg_q.run;
    rd_word[B_DIV]                       = cfg_q.div;
    rd_word[B_IE_LSB +: NUM_CNT]         = cfg_q.ie;
    rd_word[B_OVF_LSB +: NUM_CNT]        = ovf_q;
    rd_word[B_CODE_LSB +: 2*CODE_W]      = cfg_q.code;
  end
endmodule

// File: rtl/pmu_counter.sv
module pmu_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         clear,
  input  logic         inc,
  output logic [W-1:0] count,
  output logic         wrap
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_ce;

  always_comb begin
    cnt_ce = load | clear | inc;
    if (load)       cnt_d = load_val;
    else if (clear) cnt_d = '0;
    else            cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_ce) begin
      cnt_q <= cnt_d;
    end
  end

  assign wrap  = inc & ~load & ~clear & (&cnt_q);
  assign count = cnt_q;
endmodule

// File: rtl/pmu_prescaler.sv
module pmu_prescaler #(
  parameter int DIV = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clear,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pre_q, pre_d;
  logic          pre_ce;

  always_comb begin
    pre_ce = clear | run;
    if (clear)      pre_d = '0;
    else if (tick)  pre_d = '0;
    else            pre_d = pre_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else if (pre_ce) begin
      pre_q <= pre_d;
    end
  end

  assign tick = run & (pre_q == LAST);
endmodule

// File: rtl/pmu_event_sel.sv
module pmu_event_sel
  import pmu_pkg::*;
(
  input  logic [NUM_EVT-1:0] events,
  input  logic [CODE_W-1:0]  code,
  output logic               hit
);
  localparam logic [CODE_W-1:0] NONE = '1;
  assign hit = (code != NONE) & events[code];
endmodule

// File: rtl/perf_mon_unit.sv
module perf_mon_unit
  import pmu_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int PRESCALE = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [1:0]         reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  input  logic [NUM_EVT-1:0] event_pulse,
  output logic               irq
);
  logic                        rst_meta, rst_sync_n;
  pmu_cfg_t                    cfg;
  logic [NUM_CNT-1:0]          ovf_flags, wrap_vec;
  logic                        clr_evt, clr_cyc, run_en;
  logic [31:0]                 ctrl_word;
  logic                        pre_tick, cyc_inc;
  logic [CNT_W-1:0]            cyc_count;
  logic [1:0][CNT_W-1:0]       evt_count;
  logic                        wr_ctrl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  assign wr_ctrl = reg_wr & (reg_addr == SEL_CTRL);
  assign run_en  = cfg.run;

  pmu_ctrl_reg u_ctrl (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (wr_ctrl),
    .wdata   (reg_wdata),
    .wrap    (wrap_vec),
    .cfg     (cfg),
    .ovf     (ovf_flags),
    .clr_evt (clr_evt),
    .clr_cyc (clr_cyc),
    .rd_word (ctrl_word)
  );

  pmu_prescaler #(.DIV(PRESCALE)) u_pre (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .run   (run_en & cfg.div),
    .clear (clr_cyc),
    .tick  (pre_tick)
  );

  assign cyc_inc = run_en & (cfg.div ? pre_tick : 1'b1);

  pmu_counter #(.W(CNT_W)) u_cyc (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load     (reg_wr & (reg_addr == SEL_CYC)),
    .load_val (reg_wdata[CNT_W-1:0]),
    .clear    (clr_cyc),
    .inc      (cyc_inc),
    .count    (cyc_count),
    .wrap     (wrap_vec[IDX_CYC])
  );

  for (genvar k = 0; k < 2; k++) begin : g_evt
    logic hit;
    pmu_event_sel u_sel (
      .events (event_pulse),
      .code   (cfg.code[k]),
      .hit    (hit)
    );
    pmu_counter #(.W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .load     (reg_wr & (reg_addr == 2'(SEL_EVT0 + k))),
      .load_val (reg_wdata[CNT_W-1:0]),
      .clear    (clr_evt),
      .inc      (run_en & hit),
      .count    (evt_count[k]),
      .wrap     (wrap_vec[k])
    );
  end

  always_comb begin
    unique case (reg_addr)
      SEL_CTRL: reg_rdata = ctrl_word;
      SEL_CYC:  reg_rdata = 32'(cyc_count);
      SEL_EVT0: reg_rdata = 32'(evt_count[0]);
      default:  reg_rdata = 32'(evt_count[1]);
    endcase
  end

  assign irq = |(ovf_flags & cfg.ie);
endmodule

// File: rtl/pmu_checker.sv
module pmu_checker #(
  parameter int CNT_W = 32
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  reg_wr,
  input logic [1:0]            reg_addr,
  input logic [31:0]           reg_wdata,
  input logic                  run_en,
  input logic [2:0]            ovf_flags,
  input logic [CNT_W-1:0]      cyc_count,
  input logic [1:0][CNT_W-1:0] evt_count,
  input logic                  irq
);
  logic       ctl_wr;
  logic [2:0] clr_mask;
  assign ctl_wr   = reg_wr && reg_addr == 2'd0;
  assign clr_mask = ctl_wr ? reg_wdata[10:8] : 3'b000;

  assert_halt_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !reg_wr) |=> ($stable(cyc_count) && $stable(evt_count)));

  assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr |=> ((cyc_count - $past(cyc_count)) <= CNT_W'(1)));

  assert_evt_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && reg_wdata[1]) |=> (evt_count == '0));

  assert_flag_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((($past(ovf_flags) & ~ovf_flags) & ~$past(clr_mask)) == 3'b000));

  assert_no_flags_no_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flags == 3'b000) |-> !irq);

  assert_load_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd1) |=> (cyc_count == $past(reg_wdata[CNT_W-1:0])));
endmodule

bind perf_mon_unit pmu_checker #(.CNT_W(CNT_W)) u_pmu_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .run_en    (run_en),
  .ovf_flags (ovf_flags),
  .cyc_count (cyc_count),
  .evt_count (evt_count),
  .irq       (irq)
);

// File: tb/tb_perf_mon_unit.sv
`timescale 1ns/1ps
module tb_perf_mon_unit;
  logic         clk, rst_n, reg_wr, irq;
  logic [1:0]   reg_addr;
  logic [31:0]  reg_wdata, reg_rdata;
  logic [255:0] event_pulse;
  int n_checks, n_fail;
  bit done;

  perf_mon_unit dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .event_pulse(event_pulse), .irq(irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // behavioural reference model
  logic [31:0] m_cyc, m_e0, m_e1;
  bit m_run, m_div;
  bit [2:0] m_ie, m_ovf;
  bit [7:0] m_c0, m_c1;
  int m_pre;
  bit i_cyc, i_e0, i_e1, ctl, w_cyc, w_e0, w_e1;
  bit [2:0] wr_wrap, clr;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cyc = 0; m_e0 = 0; m_e1 = 0; m_run = 0; m_div = 0;
      m_ie = 0; m_ovf = 0; m_c0 = 0; m_c1 = 0; m_pre = 0;
    end else begin
      ctl   = reg_wr && reg_addr == 0;
      w_cyc = reg_wr && reg_addr == 1;
      w_e0  = reg_wr && reg_addr == 2;
      w_e1  = reg_wr && reg_addr == 3;
      i_cyc = m_run && (!m_div || m_pre == 63);
      i_e0  = m_run && m_c0 != 8'hFF && event_pulse[m_c0];
      i_e1  = m_run && m_c1 != 8'hFF && event_pulse[m_c1];
      wr_wrap = 3'b000;
      if (w_cyc) m_cyc = reg_wdata;
      else if (ctl && reg_wdata[2]) m_cyc = 0;
      else if (i_cyc) begin wr_wrap[2] = (m_cyc == 32'hFFFF_FFFF); m_cyc = m_cyc + 1; end
      if (w_e0) m_e0 = reg_wdata;
      else if (ctl && reg_wdata[1]) m_e0 = 0;
      else if (i_e0) begin wr_wrap[0] = (m_e0 == 32'hFFFF_FFFF); m_e0 = m_e0 + 1; end
      if (w_e1) m_e1 = reg_wdata;
      else if (ctl && reg_wdata[1]) m_e1 = 0;
      else if (i_e1) begin wr_wrap[1] = (m_e1 == 32'hFFFF_FFFF); m_e1 = m_e1 + 1; end
      if (ctl && reg_wdata[2]) m_pre = 0;
      else if (m_run && m_div) m_pre = (m_pre + 1) % 64;
      clr = ctl ? reg_wdata[10:8] : 3'b000;
      m_ovf = (m_ovf & ~clr) | wr_wrap;
      if (ctl) begin
        m_run = reg_wdata[0]; m_div = reg_wdata[3]; m_ie = reg_wdata[6:4];
        m_c0 = reg_wdata[19:12]; m_c1 = reg_wdata[27:20];
      end
    end
  end

  function automatic logic [31:0] m_read(input logic [1:0] a);
    case (a)
      2'd0: return {4'b0, m_c1, m_c0, 1'b0, m_ovf, 1'b0, m_ie, m_div, 3'b000} | {31'b0, m_run};
      2'd1: return m_cyc;
      2'd2: return m_e0;
      default: return m_e1;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-clock comparison with the model
  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      case (reg_addr)
        2'd0: check("R8 ctrl model", reg_rdata, m_read(2'd0));
        2'd1: check("R3 cycle model", reg_rdata, m_read(2'd1));
        default: check("R2 event model", reg_rdata, m_read(reg_addr));
      endcase
      check("R7 irq model", {31'b0, irq}, {31'b0, |(m_ovf & m_ie)});
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_addr = a;
    @(posedge clk); #1;
    check(tag, reg_rdata, exp);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    done = 1;
    summary();
    $finish;
  end

  logic [31:0] v;
  initial begin
    n_checks = 0; n_fail = 0; done = 0;
    rst_n = 0; reg_wr = 0; reg_addr = 0; reg_wdata = 0; event_pulse = '0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1;
    repeat (4) @(posedge clk);

    // R11 reset state
    for (int a = 0; a < 4; a++) rd_chk(2'(a), 32'h0, "R11 reset read");
    check("R11 irq low", {31'b0, irq}, 32'h0);

    // R1 halted: codes set, run off, pulses present
    wr(0, 32'h0020_5000);
    @(negedge clk) event_pulse = '1;
    repeat (5) @(negedge clk);
    event_pulse = '0;
    rd_chk(2, 32'h0, "R1 evt0 halted");
    rd_chk(1, 32'h0, "R1 cycle halted");

    // R2 event selection: code0=5, code1=0x80
    wr(0, 32'h0800_5001);
    @(negedge clk) event_pulse[5] = 1'b1; event_pulse[128] = 1'b1;
    @(negedge clk) event_pulse[128] = 1'b0;
    @(negedge clk) event_pulse[5] = 1'b0; event_pulse[6] = 1'b1;
    @(negedge clk) event_pulse = '0;
    rd_chk(2, 32'd2, "R2 evt0 count");
    rd_chk(3, 32'd1, "R2 evt1 count");

    // R2 code 0xFF never counts; R4 clear of event counters
    wr(0, 32'h0FF0_0003);
    @(negedge clk) event_pulse = '1;
    repeat (5) @(negedge clk);
    event_pulse = '0;
    rd_chk(3, 32'd0, "R2 evt1 with code FF");
    wr(0, 32'h0000_0000);

    // R3 divide by 64, with R4 cycle clear
    wr(0, 32'h0000_000D);
    reg_addr = 1;
    repeat (128) @(posedge clk);
    #1 check("R3 divide by 64", reg_rdata, 32'd2);
    wr(0, 32'h0000_0004);
    rd_chk(1, 32'd0, "R4 cycle clear");
    rd_chk(0, 32'd0, "R4 clear bits read 0");

    // R10 preload -10 on cycle counter, R5 flag, R7 irq
    wr(1, 32'hFFFF_FFF6);
    wr(0, 32'h0000_0041);
    reg_addr = 0;
    repeat (9) @(posedge clk);
    #1 check("R10 no flag before 10th", {31'b0, irq}, 32'h0);
    @(posedge clk); #1;
    check("R10 flag on 10th", {31'b0, irq}, 32'h1);
    check("R5 cycle flag bit10", reg_rdata & 32'h0000_0700, 32'h0000_0400);

    // R6 writing 0 to flag leaves it; R8 write-back clears and stops
    wr(0, 32'h0000_0041);
    rd_chk(0, 32'h0000_0441, "R6 zero write keeps flag");
    v = reg_rdata;
    wr(0, v & ~32'h1);
    rd_chk(0, 32'h0000_0040, "R8 write-back clears flag");
    check("R7 irq after clear", {31'b0, irq}, 32'h0);

    // R6 wrap and clear on the same clock
    wr(2, 32'hFFFF_FFFF);
    wr(0, 32'h0000_7011);
    @(negedge clk) event_pulse[7] = 1'b1;
    @(negedge clk) event_pulse[7] = 1'b0;
    rd_chk(0, 32'h0000_7111, "R5 evt0 flag bit8");
    wr(2, 32'hFFFF_FFFF);
    @(negedge clk);
    reg_wr = 1; reg_addr = 0; reg_wdata = 32'h0000_7111; event_pulse[7] = 1'b1;
    @(negedge clk);
    reg_wr = 0; event_pulse[7] = 1'b0;
    rd_chk(0, 32'h0000_7111, "R6 wrap beats clear");
    check("R7 irq held", {31'b0, irq}, 32'h1);
    wr(0, 32'h0000_0100);
    check("R6 clear after collision", {31'b0, irq}, 32'h0);

    // R9 direct write during increment on cycle counter
    wr(0, 32'h0000_0001);
    @(negedge clk);
    reg_wr = 1; reg_addr = 1; reg_wdata = 32'hFFFF_FFFF;
    @(posedge clk); #1;
    check("R9 write beats increment", reg_rdata, 32'hFFFF_FFFF);
    @(negedge clk) reg_wr = 0; reg_addr = 0;
    @(posedge clk); #1;
    check("R9 wrap after write", reg_rdata & 32'h0000_0400, 32'h0000_0400);
    wr(0, 32'h0000_0700);
    repeat (3) @(posedge clk);

    done = 1;
    summary();
    $finish;
  end
endmodule